// File: doc/BRIEF.md
# Filtered Victim Buffer

This block is a small fully associative line buffer placed beside a set-associative L1 data cache. It holds lines the L1 has just thrown out, so that a later access which misses in the L1 because of a set conflict can still be answered quickly. The processor's lookup address is presented to the L1 and to this buffer in the same cycle. The buffer's hit flag and line data come back combinationally in that same cycle, so a buffer hit costs no more than an L1 hit.

On a buffer hit the line goes back into the L1. The L1 line displaced to make room for it is written into the freed buffer entry, so the two lines trade places and no line is ever held twice.

Victims offered outside such a swap are filtered. The buffer keeps a small saturating usage counter for every L1 set, bumped on each lookup to that set and halved periodically so that old activity fades. A victim is kept only if the counter of the set it came from has reached a programmable threshold. Accepted lines fill free entries first. When no entry is free, they overwrite entries in rotating order.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty and every usage counter is zero: a lookup returns `lk_hit`=0, `lk_swap`=0 and `lk_data`=0.
- R2: A lookup hits when some valid entry holds exactly `lk_addr` (the whole address: tag in the upper bits, set index in the low `SET_W` bits). The entry's data is on `lk_data` in the same cycle. `lk_data` is 0 when there is no hit.
- R3: On a buffer hit `lk_swap` is 1. If `ev_valid` is high in that cycle, the line on `ev_addr`/`ev_data` takes the hit entry whatever its set's counter. Otherwise the entry becomes empty. Either way, the line that hit is no longer held from the next cycle on.
- R4: When `lk_valid` and `ev_valid` are both high and `ev_addr` equals `lk_addr`, the lookup hits with `ev_data` and `lk_swap`=0, and that line is not stored.
- R5: An evicted line offered outside a swap is stored only if the counter of its set (`ev_addr` low `SET_W` bits) is greater than or equal to `thresh`. Otherwise the buffer is left unchanged.
- R6: A stored line takes the lowest-numbered empty entry. When none is empty, it overwrites the entry at a rotating pointer. That pointer is 0 after reset and advances by one only on such an overwrite, so the first lines written into an empty buffer are the first to be replaced.
- R7: Each set has a 4-bit counter. It rises by one per lookup to that set and saturates at 15. Admission uses the counter's value before the current cycle's lookup.
- R8: On every 256th lookup since reset, every counter becomes half (rounded down) of the value it would otherwise take.
- R9: An insertion, swap or invalidation becomes visible to lookups in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh | input | CNT_W | Admission threshold for usage counters |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | TAG_W+SET_W | Lookup line address {tag, set} |
| lk_hit | output | 1 | Lookup found the line (buffer or same-cycle victim) |
| lk_data | output | DATA_W | Line data on hit, zero otherwise |
| lk_swap | output | 1 | Hit came from a buffer entry; the L1 should take the line and hand over its victim |
| ev_valid | input | 1 | An L1 victim line is offered this cycle |
| ev_addr | input | TAG_W+SET_W | Victim line address {tag, set} |
| ev_data | input | DATA_W | Victim line data |

## Verification
Lookup results (`lk_hit`, `lk_data`, `lk_swap`) are combinational: they are due in the same cycle the lookup is driven. Insertions, swaps and invalidations are due from the following cycle. Counter changes affect admission from the cycle after the lookup that caused them. The bench therefore drives each step on the falling edge and samples the lookup outputs shortly after it, before the rising edge that commits the step. It observes buffer contents only through later lookups. Counter values and the decay point are tracked by counting the bench's own lookups since the last reset.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
package vc_pkg;
    // Outcome of the lookup port in one cycle.
    typedef enum logic [1:0] {
        LK_IDLE,
        LK_MISS,
        LK_HIT,
        LK_FWD
    } lk_kind_e;
endpackage

// File: rtl/vc_match.sv
`timescale 1ns/1ps
module vc_match #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             match,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           free_any,
    output logic [IDX_W-1:0]               free_idx
);
    // One comparator per entry: valid and whole-address equal.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit      = |match;
        free_any = ~&vld;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx  = IDX_W'(i);
            if (!vld[i])  free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_set_counters.sv
`timescale 1ns/1ps
module vc_set_counters #(
    parameter int SETS       = 16,
    parameter int CNT_W      = 4,
    parameter int DECAY_LOG2 = 8,
    localparam int SET_W     = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [SET_W-1:0] qry_set,
    input  logic [CNT_W-1:0] thresh,
    output logic             admit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [SETS-1:0][CNT_W-1:0] cnt;
        logic [DECAY_LOG2-1:0]      acc;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       decay;

    always_comb begin
        st_d  = st_q;
        decay = 1'b0;
        if (acc_valid) begin
            if (st_q.cnt[acc_set] != CNT_MAX)
                st_d.cnt[acc_set] = st_q.cnt[acc_set] + CNT_W'(1);
            st_d.acc = st_q.acc + DECAY_LOG2'(1);
            decay    = (st_q.acc == '1);
        end
        if (decay) begin
            for (int i = 0; i < SETS; i++)
                st_d.cnt[i] = st_d.cnt[i] >> 1;
        end
    end

    assign admit = (st_q.cnt[qry_set] >= thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && st_q.cnt[acc_set] == CNT_MAX && st_q.acc != '1)
        |=> st_q.cnt[$past(acc_set)] == CNT_MAX);

    // R8
    decay_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && st_q.acc == '1)
        |=> st_q.cnt[$past(acc_set)] <= (CNT_MAX >> 1));
endmodule

// File: rtl/victim_buffer.sv
`timescale 1ns/1ps
module victim_buffer #(
    parameter int ENTRIES    = 8,
    parameter int SETS       = 16,
    parameter int TAG_W      = 8,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 4,
    parameter int DECAY_LOG2 = 8,
    localparam int SET_W     = $clog2(SETS),
    localparam int ADDR_W    = TAG_W + SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_swap,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data
);
    import vc_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic [IDX_W-1:0]               ptr;
    } buf_state_t;

    buf_state_t st_d, st_q;

    logic [ENTRIES-1:0] match_vec;
    logic               m_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic               admit;
    logic               fwd;
    logic [IDX_W-1:0]   slot;
    lk_kind_e           kind;

    vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .vld      (st_q.vld),
        .tags     (st_q.addr),
        .key      (lk_addr),
        .match    (match_vec),
        .hit      (m_hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    vc_set_counters #(.SETS(SETS), .CNT_W(CNT_W), .DECAY_LOG2(DECAY_LOG2)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (lk_valid),
        .acc_set   (lk_addr[SET_W-1:0]),
        .qry_set   (ev_addr[SET_W-1:0]),
        .thresh    (thresh),
        .admit     (admit)
    );

    always_comb begin
        st_d    = st_q;
        lk_hit  = 1'b0;
        lk_swap = 1'b0;
        lk_data = '0;
        slot    = '0;
        fwd     = lk_valid && ev_valid && (ev_addr == lk_addr);

        if (!lk_valid)  kind = LK_IDLE;
        else if (fwd)   kind = LK_FWD;
        else if (m_hit) kind = LK_HIT;
        else            kind = LK_MISS;

        case (kind)
            LK_FWD: begin
                // Victim goes straight back to the L1; nothing stored.
                lk_hit  = 1'b1;
                lk_data = ev_data;
            end
            LK_HIT: begin
                lk_hit  = 1'b1;
                lk_swap = 1'b1;
                lk_data = st_q.data[hit_idx];
                if (ev_valid) begin
                    st_d.addr[hit_idx] = ev_addr;
                    st_d.data[hit_idx] = ev_data;
                end else begin
                    st_d.vld[hit_idx] = 1'b0;
                end
            end
            default: begin
                if (ev_valid && admit) begin
                    if (free_any) begin
                        slot = free_idx;
                    end else begin
                        slot     = st_q.ptr;
                        st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0
                                 : st_q.ptr + IDX_W'(1);
                    end
                    st_d.vld[slot]  = 1'b1;
                    st_d.addr[slot] = ev_addr;
                    st_d.data[slot] = ev_data;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R3
    swap_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_swap |-> lk_hit);

    // R3
    swap_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == LK_HIT && !ev_valid) |=> !st_q.vld[$past(hit_idx)]);

    // R4
    fwd_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == LK_FWD) |=> ($stable(st_q.vld) && $stable(st_q.ptr)));

    // R5
    reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != LK_HIT && kind != LK_FWD && ev_valid && !admit)
        |=> ($stable(st_q.vld) && $stable(st_q.ptr)));

    // R6
    fill_free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != LK_HIT && kind != LK_FWD && ev_valid && admit && free_any)
        |=> $stable(st_q.ptr));
endmodule

// File: tb/victim_buffer_bench.sv
`timescale 1ns/1ps
module victim_buffer_bench;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  thresh = '0;
    logic        lk_valid = 1'b0;
    logic [11:0] lk_addr = '0;
    logic        lk_hit;
    logic [31:0] lk_data;
    logic        lk_swap;
    logic        ev_valid = 1'b0;
    logic [11:0] ev_addr = '0;
    logic [31:0] ev_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        o_hit, o_swap;
    logic [31:0] o_data;

    always #(TCLK/2) clk = ~clk;

    victim_buffer u_victim_buffer (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_data(lk_data), .lk_swap(lk_swap),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data)
    );

    typedef struct packed {
        logic        lv;
        logic [11:0] la;
        logic        ev;
        logic [11:0] ea;
        logic [31:0] ed;
        logic        x_hit;
        logic        x_swap;
        logic [31:0] x_data;
    } vec_t;

    // Threshold 0 (every victim admitted); lookups compare same-cycle outputs.
    localparam vec_t VECS [12] = '{
        '{1'b0, 12'h000, 1'b1, 12'h011, 32'hA000_0011, 1'b0, 1'b0, 32'h0},
        '{1'b1, 12'h011, 1'b0, 12'h000, 32'h0,         1'b1, 1'b1, 32'hA000_0011},
        '{1'b1, 12'h011, 1'b0, 12'h000, 32'h0,         1'b0, 1'b0, 32'h0},
        '{1'b0, 12'h000, 1'b1, 12'h021, 32'hB000_0021, 1'b0, 1'b0, 32'h0},
        '{1'b0, 12'h000, 1'b1, 12'h031, 32'hB000_0031, 1'b0, 1'b0, 32'h0},
        '{1'b1, 12'h031, 1'b1, 12'h041, 32'hB000_0041, 1'b1, 1'b1, 32'hB000_0031},
        '{1'b1, 12'h041, 1'b0, 12'h000, 32'h0,         1'b1, 1'b1, 32'hB000_0041},
        '{1'b1, 12'h021, 1'b0, 12'h000, 32'h0,         1'b1, 1'b1, 32'hB000_0021},
        '{1'b1, 12'h055, 1'b1, 12'h055, 32'hC000_0055, 1'b1, 1'b0, 32'hC000_0055},
        '{1'b1, 12'h055, 1'b0, 12'h000, 32'h0,         1'b0, 1'b0, 32'h0},
        '{1'b1, 12'h031, 1'b0, 12'h000, 32'h0,         1'b0, 1'b0, 32'h0},
        '{1'b1, 12'h000, 1'b0, 12'h000, 32'h0,         1'b0, 1'b0, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic lv, input logic [11:0] la,
                        input logic ev, input logic [11:0] ea, input logic [31:0] ed);
        @(negedge clk);
        lk_valid = lv; lk_addr = la;
        ev_valid = ev; ev_addr = ea; ev_data = ed;
        #2;
        o_hit = lk_hit; o_swap = lk_swap; o_data = lk_data;
        @(posedge clk);
    endtask

    task automatic look(input logic [11:0] a);
        step(1'b1, a, 1'b0, 12'h000, 32'h0);
    endtask

    task automatic put(input logic [11:0] a, input logic [31:0] d);
        step(1'b0, 12'h000, 1'b1, a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lk_valid = 1'b0; ev_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: empty after reset
        look(12'h011);
        check("R1 hit", {31'b0, o_hit}, 32'h0);
        check("R1 swap", {31'b0, o_swap}, 32'h0);
        check("R1 data", o_data, 32'h0);

        do_reset();
        thresh = 4'd0;
        // R2 R3 R4 R9: vector walk
        foreach (VECS[i]) begin
            step(VECS[i].lv, VECS[i].la, VECS[i].ev, VECS[i].ea, VECS[i].ed);
            if (VECS[i].lv) begin
                check($sformatf("R2/R3/R4 vec%0d hit", i), {31'b0, o_hit}, {31'b0, VECS[i].x_hit});
                check($sformatf("R3/R4 vec%0d swap", i), {31'b0, o_swap}, {31'b0, VECS[i].x_swap});
                check($sformatf("R2/R9 vec%0d data", i), o_data, VECS[i].x_data);
            end
        end

        // R6: fill, rotate, free-first
        do_reset();
        thresh = 4'd0;
        for (int t = 1; t <= 9; t++) put({8'(t), 4'h2}, 32'hF000_0000 | 32'(t));
        look({8'd1, 4'h2});
        check("R6 oldest replaced", {31'b0, o_hit}, 32'h0);
        look({8'd9, 4'h2});
        check("R6 newest present", o_data, 32'hF000_0009);
        put({8'd10, 4'h2}, 32'hF000_000A);
        put({8'd11, 4'h2}, 32'hF000_000B);
        look({8'd2, 4'h2});
        check("R6 pointer victim", {31'b0, o_hit}, 32'h0);
        look({8'd3, 4'h2});
        check("R6 free slot used first", o_data, 32'hF000_0003);
        look({8'd10, 4'h2});
        check("R6 line in free slot", o_data, 32'hF000_000A);
        look({8'd11, 4'h2});
        check("R6 line at pointer", o_data, 32'hF000_000B);
        look({8'd8, 4'h2});
        check("R6 untouched line", o_data, 32'hF000_0008);

        // R1: reset clears held lines
        do_reset();
        look({8'd4, 4'h2});
        check("R1 cleared entry", {31'b0, o_hit}, 32'h0);

        // R5 R7: threshold filter
        do_reset();
        thresh = 4'd3;
        look(12'h105);
        look(12'h105);
        put(12'h205, 32'hD000_0001);
        look(12'h205);
        check("R5 below threshold rejected", {31'b0, o_hit}, 32'h0);
        put(12'h205, 32'hD000_0002);
        look(12'h205);
        check("R5 at threshold admitted", {31'b0, o_hit}, 32'h1);
        check("R7 admitted data", o_data, 32'hD000_0002);
        put(12'h206, 32'hD000_0003);
        look(12'h206);
        check("R5 cold set rejected", {31'b0, o_hit}, 32'h0);

        // R7 R8: saturation then decay
        do_reset();
        thresh = 4'd15;
        for (int k = 0; k < 20; k++) look(12'h707);
        put(12'h717, 32'hE000_0001);
        look(12'h717);
        check("R7 saturated counter admits", o_data, 32'hE000_0001);
        for (int k = 0; k < 235; k++) look(12'h000);
        thresh = 4'd8;
        put(12'h727, 32'hE000_0002);
        look(12'h727);
        check("R8 halved counter rejects", {31'b0, o_hit}, 32'h0);
        put(12'h737, 32'hE000_0003);
        look(12'h737);
        check("R8 counter regrows", o_data, 32'hE000_0003);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule